// File: doc/BRIEF.md
# Dynamic Bus Width Adapter

This block turns one 32-bit processor-side request into the external bus cycles needed for a device that may be 32, 16 or 8 bits wide. The device width is not configured: address decoding reports it on every external cycle through two active-low size inputs. The adapter samples them together with the device's ready. When the device is narrower than the bytes still pending, the adapter starts further sub-transfers, lowest-addressed bytes first, until every enabled byte has moved.

On each external cycle the adapter drives the word address, the still-pending byte enables, and the address bits and half-word strobes decoded from those enables. The address bit A0 and the active-low low-byte strobe come from the same decoder output. Write data is copied down onto the low lanes that a narrow device uses. Read data arriving on the low lanes is put back in its proper lane of the 32-bit result. A request with no byte enabled completes without any external cycle.

The controller has three states. In `ST_IDLE` it waits for a request. The transition idle→xfer is taken when the request has at least one byte enabled. The transition idle→done is taken when the request has none. In `ST_XFER` the external cycle is active. The transition xfer→xfer is taken on ready when bytes remain, or while ready is high. The transition xfer→done is taken on ready when the final bytes are moved. `ST_DONE` pulses completion and returns to idle (done→idle).

Top module: `bus_width_adapter`

## Requirements
- R1: After synchronous active-high reset the adapter is idle. `ext_cyc` and `req_done` are low, `ext_be_n` is 4'hF, and `ext_ble_n` and `ext_bhe_n` are high.
- R2: When a cycle is acknowledged with neither size input asserted (32-bit device), all pending enabled bytes move in that one cycle. Byte i travels on data bits 8i+7:8i, with the lowest address on bits 7:0.
- R3: During a cycle, `ext_a1` is 1 exactly when neither byte 0 nor byte 1 is still pending. `ext_ble_n` is low when byte 2·A1 is pending. `ext_bhe_n` is low when byte 2·A1+1 is pending. On a 16-bit acknowledge (`ext_bs16_n` low, `ext_bs8_n` high), the pending bytes of that half move.
- R4: During a cycle, {`ext_a1`,`ext_a0`} is the index of the lowest pending byte, and `ext_a0` always equals `ext_ble_n`. On an 8-bit acknowledge (`ext_bs8_n` low), only that one byte moves.
- R5: `ext_be_n` shows, active low, the bytes not yet moved. Each acknowledge removes the lowest pending byte and never adds one. Further cycles follow until none remain.
- R6: Size inputs are sampled only on the edge where `ext_rdy_n` is low, and are ignored during wait states. When both are asserted, the 8-bit width wins. Successive sub-cycles may report different widths in any order.
- R7: On a write, `ext_wdata[7:0]` carries the lowest pending byte. `ext_wdata[15:8]` carries byte 3 when A1 is 1 and byte 1 otherwise. The upper lanes carry bytes 3:2.
- R8: On a read, `req_rdata` holds every enabled byte in its own lane, taken from the lane the reported width uses. Non-enabled bytes read as zero.
- R9: A request with `req_be_n` = 4'hF raises `req_done` in the cycle after acceptance and never raises `ext_cyc`.
- R10: `req_done` is a one-cycle pulse that follows the edge of the final acknowledge. `req_rdata` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_addr | input | ADDR_W | Word address |
| req_be_n | input | 4 | Active-low byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, byte i on bits 8i+7:8i |
| req_done | output | 1 | Completion pulse |
| req_rdata | output | 32 | Assembled read data |
| ext_cyc | output | 1 | External cycle active |
| ext_write | output | 1 | External cycle direction |
| ext_addr | output | ADDR_W | Word address on the device bus |
| ext_be_n | output | 4 | Pending byte enables, active low |
| ext_a1 | output | 1 | Decoded address bit 1 |
| ext_a0 | output | 1 | Decoded address bit 0 |
| ext_ble_n | output | 1 | Low-byte strobe of the half-word, active low |
| ext_bhe_n | output | 1 | High-byte strobe of the half-word, active low |
| ext_wdata | output | 32 | Steered write data |
| ext_rdata | input | 32 | Read data from the device |
| ext_rdy_n | input | 1 | Device ready, active low |
| ext_bs16_n | input | 1 | 16-bit device select, active low |
| ext_bs8_n | input | 1 | 8-bit device select, active low |

## Verification
The bench models a device whose width is chosen per sub-cycle. It predicts the pending-byte set, A1, A0 and both strobes before every acknowledge. This exposes a design that moves bytes out of address order, or that decodes A1 from the original enables instead of the remaining ones.

Sparse patterns such as bytes 1 and 3 on an 8-bit device, or bytes 1 and 2 on a 16-bit device, catch wrong lane copies: a broken steering path writes the wrong byte into the modelled memory. Wait states with both size inputs asserted while ready is high reveal a design that samples width early and splits a 32-bit transfer. Empty requests and mixed width sequences check for a stray external cycle, and for completion arriving early or late.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    localparam int BYTES = 4;

    typedef enum logic [1:0] {
        BW_32 = 2'd0,
        BW_16 = 2'd1,
        BW_8  = 2'd2
    } bus_w_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } st_e;

    // 8-bit select has priority over 16-bit select
    function automatic bus_w_e width_of(input logic bs16_n, input logic bs8_n);
        if (!bs8_n)       return BW_8;
        else if (!bs16_n) return BW_16;
        else              return BW_32;
    endfunction

endpackage

// File: rtl/bwa_strobe_dec.sv
module bwa_strobe_dec
    import bwa_pkg::*;
(
    input  logic [BYTES-1:0] pend,
    output logic             a1,
    output logic             a0,
    output logic             ble_n,
    output logic             bhe_n
);
    logic [1:0] half;

    always_comb begin
        a1    = ~(pend[0] | pend[1]);
        half  = a1 ? pend[3:2] : pend[1:0];
        // one decoder output serves both the byte address bit and the low strobe
        a0    = ~half[0];
        ble_n = a0;
        bhe_n = ~half[1];
    end
endmodule

// File: rtl/bwa_lane_steer.sv
module bwa_lane_steer
    import bwa_pkg::*;
(
    input  bus_w_e           width,
    input  logic [BYTES-1:0] pend,
    input  logic             a1,
    input  logic             a0,
    input  logic [31:0]      wdata,
    input  logic [31:0]      rdata_bus,
    input  logic [31:0]      rbuf,
    output logic [BYTES-1:0] moved,
    output logic [31:0]      wdata_bus,
    output logic [31:0]      rbuf_nx
);
    localparam int IDX_W = $clog2(BYTES);

    logic [IDX_W-1:0] low_idx;

    always_comb begin
        low_idx = {a1, a0};
        unique case (width)
            BW_32:   moved = pend;
            BW_16:   moved = pend & (a1 ? 4'b1100 : 4'b0011);
            BW_8:    moved = 4'b0001 << low_idx;
            default: moved = pend;
        endcase
        wdata_bus[31:16] = wdata[31:16];
        wdata_bus[15:8]  = a1 ? wdata[31:24] : wdata[15:8];
        wdata_bus[7:0]   = wdata[8*low_idx +: 8];
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        logic [7:0] src;
        always_comb begin
            unique case (width)
                BW_32:   src = rdata_bus[8*g +: 8];
                BW_16:   src = rdata_bus[8*(g%2) +: 8];
                BW_8:    src = rdata_bus[7:0];
                default: src = rdata_bus[8*g +: 8];
            endcase
            rbuf_nx[8*g +: 8] = moved[g] ? src : rbuf[8*g +: 8];
        end
    end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be_n,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              req_done,
    output logic [31:0]       req_rdata,
    output logic              ext_cyc,
    output logic              ext_write,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [3:0]        ext_be_n,
    output logic              ext_a1,
    output logic              ext_a0,
    output logic              ext_ble_n,
    output logic              ext_bhe_n,
    output logic [31:0]       ext_wdata,
    input  logic [31:0]       ext_rdata,
    input  logic              ext_rdy_n,
    input  logic              ext_bs16_n,
    input  logic              ext_bs8_n
);
    st_e               state_q, state_nx;
    logic [BYTES-1:0]  pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [31:0]       wdata_q, rbuf_q, rbuf_nx, wbus;
    logic [BYTES-1:0]  moved;
    logic              d_a1, d_a0, d_ble_n, d_bhe_n;
    bus_w_e            width;
    logic              ack, last;

    assign width = width_of(ext_bs16_n, ext_bs8_n);
    assign ack   = (state_q == ST_XFER) && !ext_rdy_n;
    assign last  = (pend_q & ~moved) == '0;

    bwa_strobe_dec u_dec (
        .pend  (pend_q),
        .a1    (d_a1),
        .a0    (d_a0),
        .ble_n (d_ble_n),
        .bhe_n (d_bhe_n)
    );

    bwa_lane_steer u_lane (
        .width     (width),
        .pend      (pend_q),
        .a1        (d_a1),
        .a0        (d_a0),
        .wdata     (wdata_q),
        .rdata_bus (ext_rdata),
        .rbuf      (rbuf_q),
        .moved     (moved),
        .wdata_bus (wbus),
        .rbuf_nx   (rbuf_nx)
    );

    // next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_nx = (&req_be_n) ? ST_DONE : ST_XFER;
            ST_XFER: if (ack && last) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    // request datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rbuf_q  <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            pend_q  <= ~req_be_n;
            addr_q  <= req_addr;
            write_q <= req_write;
            wdata_q <= req_wdata;
            rbuf_q  <= '0;
        end else if (ack) begin
            pend_q <= pend_q & ~moved;
            if (!write_q) rbuf_q <= rbuf_nx;
        end
    end

    // outputs
    always_comb begin
        ext_cyc   = (state_q == ST_XFER);
        ext_write = ext_cyc && write_q;
        ext_addr  = addr_q;
        ext_be_n  = ext_cyc ? ~pend_q : 4'hF;
        ext_a1    = ext_cyc ? d_a1 : 1'b0;
        ext_a0    = ext_cyc ? d_a0 : 1'b0;
        ext_ble_n = ext_cyc ? d_ble_n : 1'b1;
        ext_bhe_n = ext_cyc ? d_bhe_n : 1'b1;
        ext_wdata = wbus;
        req_done  = (state_q == ST_DONE);
        req_rdata = rbuf_q;
    end

    AST_QUIET_OUTSIDE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !ext_cyc |-> (ext_be_n == 4'hF) && ext_ble_n && ext_bhe_n); // R1
    AST_PENDING_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        ack |=> ((pend_q & ~$past(pend_q)) == '0) && (pend_q != $past(pend_q))); // R5
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
        ack |=> !pend_q[$past({d_a1, d_a0})]); // R5
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ext_cyc && ext_rdy_n) |=> ext_cyc && $stable(ext_be_n)); // R6
    AST_EMPTY_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req_valid && (&req_be_n)) |=> req_done && !ext_cyc); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done); // R10

endmodule

// File: tb/sim_bus_width_adapter.sv
module sim_bus_width_adapter;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [29:0] req_addr;
    logic [3:0]  req_be_n;
    logic        req_write;
    logic [31:0] req_wdata;
    logic        req_done;
    logic [31:0] req_rdata;
    logic        ext_cyc, ext_write;
    logic [29:0] ext_addr;
    logic [3:0]  ext_be_n;
    logic        ext_a1, ext_a0, ext_ble_n, ext_bhe_n;
    logic [31:0] ext_wdata;
    logic [31:0] ext_rdata;
    logic        ext_rdy_n, ext_bs16_n, ext_bs8_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] dmem [4];

    always #2 clk = ~clk;

    bus_width_adapter #(.ADDR_W(30)) u0 (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // seq holds 2 bits per sub-cycle: 0=32, 1=16, 2=8, 3=both selects low
    task automatic run_req(input logic [3:0] be_n, input bit wr, input logic [31:0] wd,
                           input logic [15:0] seq, input int waits, input int exp_cyc);
        logic [3:0]  pend;
        logic [7:0]  expmem [4];
        logic [31:0] exp_rd;
        int k, since, wc;
        bit seen;
        logic [1:0] li, w;
        logic [3:0] mv;
        pend = ~be_n;
        exp_rd = '0;
        for (int i = 0; i < 4; i++) begin
            expmem[i] = (wr && !be_n[i]) ? wd[8*i +: 8] : dmem[i];
            if (!be_n[i]) exp_rd[8*i +: 8] = dmem[i];
        end
        req_valid = 1'b1; req_addr = 30'h1234567; req_be_n = be_n;
        req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0; since = 0; wc = 0; seen = 0;
        for (int it = 0; it < 40 && !seen; it++) begin
            since++;
            ext_rdy_n = 1'b1; ext_bs16_n = 1'b1; ext_bs8_n = 1'b1;
            if (req_done) begin
                seen = 1;
                check(since == 1, "R10 done follows final ready", since, 1);
                check(k == exp_cyc, "R5 sub-cycle count", k, exp_cyc);
                if (!wr) check(req_rdata == exp_rd, "R8 assembled read", req_rdata, exp_rd);
            end else if (ext_cyc) begin
                if (exp_cyc == 0) check(0, "R9 no cycle for empty request", 1, 0);
                li = pend[0] ? 2'd0 : pend[1] ? 2'd1 : pend[2] ? 2'd2 : 2'd3;
                check(ext_be_n == ~pend, "R5 pending enables", ext_be_n, ~pend);
                check({ext_a1, ext_a0} == li, "R4 A1:A0 lowest byte", {ext_a1, ext_a0}, li);
                check(ext_ble_n == !pend[{li[1], 1'b0}] && ext_bhe_n == !pend[{li[1], 1'b1}],
                      "R3 half-word strobes", {ext_ble_n, ext_bhe_n},
                      {!pend[{li[1], 1'b0}], !pend[{li[1], 1'b1}]});
                check(ext_a0 == ext_ble_n, "R4 A0 equals low strobe", ext_a0, ext_ble_n);
                if (wc < waits) begin
                    wc++;
                    ext_bs16_n = 1'b0; ext_bs8_n = 1'b0; // R6 noise while not ready
                end else begin
                    wc = 0;
                    w = seq[2*k +: 2];
                    ext_rdy_n = 1'b0;
                    ext_bs16_n = !(w == 2'd1 || w == 2'd3);
                    ext_bs8_n  = !(w[1]);
                    if (w == 2'd0)       mv = pend;
                    else if (w == 2'd1)  mv = pend & (li[1] ? 4'b1100 : 4'b0011);
                    else                 mv = 4'b0001 << li;
                    if (w == 2'd0)
                        ext_rdata = {dmem[3], dmem[2], dmem[1], dmem[0]};
                    else if (w == 2'd1)
                        ext_rdata = {16'hDEAD, dmem[{li[1], 1'b1}], dmem[{li[1], 1'b0}]};
                    else
                        ext_rdata = {24'hEEEEEE, dmem[li]};
                    if (wr) begin
                        if (w == 2'd0) begin
                            for (int i = 0; i < 4; i++)
                                if (!ext_be_n[i]) dmem[i] = ext_wdata[8*i +: 8];
                        end else if (w == 2'd1) begin
                            if (!ext_ble_n) dmem[{ext_a1, 1'b0}] = ext_wdata[7:0];
                            if (!ext_bhe_n) dmem[{ext_a1, 1'b1}] = ext_wdata[15:8];
                        end else begin
                            dmem[{ext_a1, ext_a0}] = ext_wdata[7:0];
                        end
                    end
                    pend = pend & ~mv;
                    k++;
                    since = 0;
                end
            end
            @(negedge clk);
        end
        ext_rdy_n = 1'b1; ext_bs16_n = 1'b1; ext_bs8_n = 1'b1;
        check(seen, "R10 done observed", seen, 1);
        if (wr)
            for (int i = 0; i < 4; i++)
                check(dmem[i] == expmem[i], "R7 written byte", dmem[i], expmem[i]);
    endtask

    task automatic fill(input logic [31:0] v);
        for (int i = 0; i < 4; i++) dmem[i] = v[8*i +: 8];
    endtask

    task automatic t_reset;
        check(!ext_cyc && !req_done && ext_be_n == 4'hF && ext_ble_n && ext_bhe_n,
              "R1 reset state", {ext_cyc, req_done, ext_be_n, ext_ble_n, ext_bhe_n}, 8'h3F);
    endtask
    task automatic t_read32;  fill(32'h44332211); run_req(4'b0000, 0, '0, 16'h0000, 0, 1); endtask // R2
    task automatic t_write16; fill(32'h0); run_req(4'b0000, 1, 32'hA1B2C3D4, 16'h0005, 0, 2); endtask // R3 R7
    task automatic t_w16_hi;  fill(32'h55555555); run_req(4'b0011, 1, 32'h9988_7766, 16'h0001, 0, 1); endtask // R7
    task automatic t_read8;   fill(32'hCAFEF00D); run_req(4'b0000, 0, '0, 16'h00AA, 0, 4); endtask // R4
    task automatic t_w8_odd;  fill(32'h11111111); run_req(4'b0101, 1, 32'h7A6B5C4D, 16'h000A, 0, 2); endtask // R7
    task automatic t_mixed;   fill(32'h87654321); run_req(4'b0000, 0, '0, 16'h0009, 0, 3); endtask // R6
    task automatic t_both;    fill(32'h0BADBEEF); run_req(4'b1000, 0, '0, 16'h003F, 0, 3); endtask // R6
    task automatic t_waits;   fill(32'h13579BDF); run_req(4'b0000, 0, '0, 16'h0000, 2, 1); endtask // R6
    task automatic t_empty;   fill(32'h0); run_req(4'b1111, 0, '0, 16'h0000, 0, 0); endtask // R9
    task automatic t_sparse;  fill(32'hF1E2D3C4); run_req(4'b1001, 0, '0, 16'h0005, 0, 2); endtask // R8

    bit finished = 0;

    initial begin
        for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_be_n = 4'hF;
        req_write = 1'b0; req_wdata = '0; ext_rdata = '0;
        ext_rdy_n = 1'b1; ext_bs16_n = 1'b1; ext_bs8_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_read32;
        t_write16;
        t_w16_hi;
        t_read8;
        t_w8_odd;
        t_mixed;
        t_both;
        t_waits;
        t_empty;
        t_sparse;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule